// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit counter with a companion reload register. It advances once for every cycle in which its `tick` input is high. In its default mode the counter only counts upward. When it passes the all-ones value it restarts from the reload register and raises a sticky overflow flag. Software can also allow a falling edge on an external pin to restart the count from the reload register. That edge raises a second sticky flag, the pin flag.

When software sets the bidirectional mode bit, the external pin selects the counting direction instead of requesting a reload. With the pin high the counter counts up and wraps to the reload value. With the pin low it counts down. When the count reaches the reload value, the next tick loads all-ones and sets the overflow flag. In this mode the pin flag flips on every wrap, so software can read it as a seventeenth count bit, and it does not raise the interrupt.

Software reaches the control word, the count and the reload value through a single-cycle write, combinational-read register port. The interrupt output is meant for a system interrupt controller. Neither flag is cleared by hardware. Software clears a flag by writing the control word.

Top module: `udTimer`

## Requirements
- R1: After reset the count, the reload value and the control word all read 0, and `irq` is low. The block is therefore in up-only mode with both flags clear.
- R2: Register map. Address 0 is the control word: bit 0 is the pin-reload enable, bit 1 is the bidirectional mode, bit 2 is the overflow flag and bit 3 is the pin flag. Address 1 is the count and address 2 is the reload value. Address 3 reads 0. A control write sets all four bits from the write data.
- R3: In up-only mode each tick adds one to the count. A tick at 0xFFFF loads the reload value and sets the overflow flag.
- R4: In up-only mode with the pin-reload enable set, a falling edge on `extPin` loads the reload value and sets the pin flag whether or not a tick is present. The edge is taken after a two-flop synchroniser, so the count changes on the third rising clock edge after the pin falls. With the enable clear, the edge has no effect.
- R5: In bidirectional mode with the synchronised pin high, each tick adds one to the count. A tick at 0xFFFF loads the reload value and sets the overflow flag.
- R6: In bidirectional mode with the synchronised pin low, each tick subtracts one from the count. A tick while the count equals the reload value loads 0xFFFF and sets the overflow flag.
- R7: In bidirectional mode every wrap, up or down, inverts the pin flag. A falling pin edge causes no reload. The pin flag does not drive `irq`.
- R8: `irq` is high whenever the overflow flag is set, or the pin flag is set in up-only mode. Both flags keep their value until a control write changes them.
- R9: A count write takes effect even when a tick, wrap or pin reload falls in the same cycle.
- R10: With no tick and no register write, the count holds in bidirectional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per step |
| extPin | input | 1 | External pin, asynchronous |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from `regAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit width and two synchroniser stages. At this width the wrap at 0xFFFF and the match against the reload value are reached by writing a count close to them and then ticking. The two-stage setting fixes the three-cycle latency from the pin to the count, which the directed pin cases check exactly. Random count writes near all-ones, together with random pin toggles and control writes, make wraps in both directions, pin reloads and write collisions happen often during the random phase.

// File: rtl/udtimer_pkg.sv
package udtimer_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_COUNT  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_RELOAD = 2'd2;

  localparam int BIT_PINEN = 0;
  localparam int BIT_BIDIR = 1;
  localparam int BIT_OVF   = 2;
  localparam int BIT_PINF  = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic swCount;
    logic swReload;
    logic loadReload;
    logic loadMax;
    logic inc;
    logic dec;
  } dpStrobe_t;
endpackage

// File: rtl/udTimerDp.sv
module udTimerDp
  import udtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] reload,
  output logic             atMax,
  output logic             atReload
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      reload <= '0;
    end else begin
      if (strobe.swReload) reload <= wdata;
      if (strobe.swCount)         count <= wdata;
      else if (strobe.loadReload) count <= reload;
      else if (strobe.loadMax)    count <= MAX_VAL;
      else if (strobe.inc)        count <= count + ONE;
      else if (strobe.dec)        count <= count - ONE;
    end
  end

  assign atMax    = (count == MAX_VAL);
  assign atReload = (count == reload);
endmodule

// File: rtl/udTimerCtrl.sv
module udTimerCtrl
  import udtimer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extPin,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  input  logic              atMax,
  input  logic              atReload,
  output dpStrobe_t         strobe,
  output logic              pinEn,
  output logic              bidir,
  output logic              ovfFlag,
  output logic              pinFlag,
  output logic              dirUp,
  output logic              fallEdge
);
  // One extra stage beyond the synchroniser keeps the previous level for edge detection.
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
  end

  assign dirUp    = syncQ[SYNC_STAGES-1];
  assign fallEdge = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];

  logic wrCtrl, goUp, wrapUp, wrapDown, pinReload;

  always_comb begin
    wrCtrl    = regWr && (regAddr == ADDR_CTRL);
    goUp      = !bidir || dirUp;
    wrapUp    = tick && goUp && atMax;
    wrapDown  = tick && !goUp && atReload;
    pinReload = !bidir && pinEn && fallEdge;

    strobe.swCount    = regWr && (regAddr == ADDR_COUNT);
    strobe.swReload   = regWr && (regAddr == ADDR_RELOAD);
    strobe.loadReload = wrapUp || pinReload;
    strobe.loadMax    = wrapDown;
    strobe.inc        = tick && goUp && !atMax;
    strobe.dec        = tick && !goUp && !atReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinEn   <= 1'b0;
      bidir   <= 1'b0;
      ovfFlag <= 1'b0;
      pinFlag <= 1'b0;
    end else if (wrCtrl) begin
      pinEn   <= regWdata[BIT_PINEN];
      bidir   <= regWdata[BIT_BIDIR];
      ovfFlag <= regWdata[BIT_OVF];
      pinFlag <= regWdata[BIT_PINF];
    end else begin
      if (wrapUp || wrapDown) ovfFlag <= 1'b1;
      if (bidir && (wrapUp || wrapDown)) pinFlag <= ~pinFlag;
      else if (pinReload)                pinFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/udTimer.sv
module udTimer
  import udtimer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extPin,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  output logic              irq
);
  dpStrobe_t        strobe;
  logic [WIDTH-1:0] count, reload;
  logic             atMax, atReload;
  logic             pinEn, bidir, ovfFlag, pinFlag, dirUp, fallEdge;

  udTimerCtrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .extPin(extPin),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .atMax(atMax), .atReload(atReload), .strobe(strobe),
    .pinEn(pinEn), .bidir(bidir), .ovfFlag(ovfFlag), .pinFlag(pinFlag),
    .dirUp(dirUp), .fallEdge(fallEdge)
  );

  udTimerDp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .count(count), .reload(reload), .atMax(atMax), .atReload(atReload)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[BIT_PINEN] = pinEn;
        regRdata[BIT_BIDIR] = bidir;
        regRdata[BIT_OVF]   = ovfFlag;
        regRdata[BIT_PINF]  = pinFlag;
      end
      ADDR_COUNT:  regRdata = count;
      ADDR_RELOAD: regRdata = reload;
      default:     regRdata = '0;
    endcase
  end

  assign irq = ovfFlag | (pinFlag & ~bidir);
endmodule

// File: rtl/udTimerChk.sv
module udTimerChk
  import udtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              regWr,
  input logic [REG_AW-1:0] regAddr,
  input logic [WIDTH-1:0]  regWdata,
  input logic [WIDTH-1:0]  count,
  input logic [WIDTH-1:0]  reload,
  input logic              bidir,
  input logic              dirUp,
  input logic              ovfFlag,
  input logic              pinFlag,
  input logic              irq
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick && !bidir && count == MAX_VAL && !regWr |=> count == $past(reload) && ovfFlag);

  p_down_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    tick && bidir && !dirUp && count == reload && !regWr |=> count == MAX_VAL && ovfFlag);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick && bidir && !dirUp && count == reload && !regWr |=> pinFlag != $past(pinFlag));

  p_no_pin_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    bidir && !ovfFlag |-> !irq);

  p_ovf_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> irq);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(regWr && regAddr == ADDR_CTRL) |=> ovfFlag);

  p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == ADDR_COUNT |=> count == $past(regWdata));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !tick && bidir && !regWr |=> $stable(count));
endmodule

bind udTimer udTimerChk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .count(count), .reload(reload), .bidir(bidir),
  .dirUp(dirUp), .ovfFlag(ovfFlag), .pinFlag(pinFlag), .irq(irq)
);

// File: tb/udTimer_tb.sv
`timescale 1ns/100ps
module udTimer_tb;
  localparam int W = 16;
  localparam logic [W-1:0] MAXV = 16'hFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, extPin = 1'b0, regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic irq;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench reference state
  logic [W-1:0] mCount, mReload;
  logic mPinEn, mBidir, mOvf, mPinF;
  logic mS1, mS2, mS3;

  always #2.5 clk = ~clk;

  udTimer u_dut (.clk(clk), .rstN(rstN), .tick(tick), .extPin(extPin), .regWr(regWr),
                 .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq));

  function automatic logic [W-1:0] expCtrl();
    return {12'd0, mPinF, mOvf, mBidir, mPinEn};
  endfunction

  function automatic logic expIrq();
    return mOvf | (mPinF & ~mBidir);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mCount = '0; mReload = '0; mPinEn = 0; mBidir = 0; mOvf = 0; mPinF = 0;
    mS1 = 0; mS2 = 0; mS3 = 0;
  endtask

  task automatic modelStep(logic t, logic p, logic w, logic [1:0] a, logic [W-1:0] d);
    logic fall, goUp;
    logic [W-1:0] nc;
    logic nOvf, nPinF;
    fall = mS3 & ~mS2;
    goUp = !mBidir || mS2;
    nc = mCount; nOvf = mOvf; nPinF = mPinF;
    if (t) begin
      if (goUp) begin
        if (mCount == MAXV) begin nc = mReload; nOvf = 1; if (mBidir) nPinF = ~nPinF; end
        else nc = mCount + 16'd1;
      end else begin
        if (mCount == mReload) begin nc = MAXV; nOvf = 1; nPinF = ~nPinF; end
        else nc = mCount - 16'd1;
      end
    end
    if (!mBidir && mPinEn && fall) begin nc = mReload; nPinF = 1; end
    if (w && a == 2'd0) begin
      mPinEn = d[0]; mBidir = d[1]; nOvf = d[2]; nPinF = d[3];
    end
    if (w && a == 2'd1) nc = d;
    if (w && a == 2'd2) mReload = d;
    mCount = nc; mOvf = nOvf; mPinF = nPinF;
    mS3 = mS2; mS2 = mS1; mS1 = p;
  endtask

  task automatic readReg(logic [1:0] a, output logic [W-1:0] v);
    regWr = 0; regAddr = a; #1; v = regRdata;
  endtask

  // called at a negedge; compares the current count and irq, applies one cycle of stimulus
  task automatic doCycle(string tag, logic t, logic w, logic [1:0] a, logic [W-1:0] d);
    logic [W-1:0] v;
    readReg(2'd1, v);
    check({tag, " count"}, v, mCount);
    check({tag, " irq"}, {15'd0, irq}, {15'd0, expIrq()});
    tick = t; regWr = w; regAddr = a; regWdata = d;
    @(posedge clk);
    modelStep(t, extPin, w, a, d);
    @(negedge clk);
    tick = 0; regWr = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) doCycle(tag, 0, 0, 0, 0);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [W-1:0] d);
    doCycle(tag, 0, 1, a, d);
  endtask

  task automatic checkCtrl(string tag);
    logic [W-1:0] v;
    readReg(2'd0, v);
    check(tag, v, expCtrl());
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd1357));
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    readReg(2'd0, v); check("R1 ctrl", v, 16'h0000);
    readReg(2'd1, v); check("R1 count", v, 16'h0000);
    readReg(2'd2, v); check("R1 reload", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    readReg(2'd3, v); check("R2 spare address", v, 16'h0000);

    // R3 up-only wrap
    wr("R2", 2'd2, 16'h1234);
    wr("R2", 2'd1, 16'hFFFE);
    readReg(2'd2, v); check("R2 reload readback", v, 16'h1234);
    doCycle("R3", 1, 0, 0, 0);
    doCycle("R3", 1, 0, 0, 0);
    readReg(2'd1, v); check("R3 wrap loads reload", v, 16'h1234);
    readReg(2'd0, v); check("R3 overflow flag", v, 16'h0004);

    // R8 flags are sticky, cleared by control write
    idle("R8", 4);
    check("R8 irq held", {15'd0, irq}, 16'd1);
    wr("R8", 2'd0, 16'h0000);
    check("R8 irq cleared", {15'd0, irq}, 16'd0);

    // R4 pin edge ignored when disabled, then reloads when enabled
    wr("R4", 2'd1, 16'h0042);
    extPin = 1; idle("R4", 3);
    extPin = 0; idle("R4", 4);
    readReg(2'd1, v); check("R4 edge ignored", v, 16'h0042);
    wr("R4", 2'd0, 16'h0001);
    extPin = 1; idle("R4", 3);
    extPin = 0; idle("R4", 2);
    readReg(2'd1, v); check("R4 not yet", v, 16'h0042);
    idle("R4", 1);
    readReg(2'd1, v); check("R4 pin reload", v, 16'h1234);
    checkCtrl("R4 pin flag");
    check("R8 pin flag irq", {15'd0, irq}, 16'd1);

    // R5 bidirectional, pin high counts up and wraps
    wr("R5", 2'd0, 16'h0002);
    extPin = 1; idle("R5", 3);
    wr("R5", 2'd1, 16'hFFFF);
    doCycle("R5", 1, 0, 0, 0);
    readReg(2'd1, v); check("R5 wrap up", v, 16'h1234);
    readReg(2'd0, v); check("R7 toggle on up wrap", v, 16'h000E);
    wr("R7", 2'd0, 16'h000A);
    check("R7 pin flag no irq", {15'd0, irq}, 16'd0);

    // R6 pin low counts down and wraps at reload
    extPin = 0; idle("R6", 3);
    wr("R6", 2'd2, 16'h0010);
    wr("R6", 2'd1, 16'h0012);
    doCycle("R6", 1, 0, 0, 0);
    doCycle("R6", 1, 0, 0, 0);
    readReg(2'd1, v); check("R6 down to reload", v, 16'h0010);
    doCycle("R6", 1, 0, 0, 0);
    readReg(2'd1, v); check("R6 underflow", v, 16'hFFFF);
    readReg(2'd0, v); check("R7 toggle on down wrap", v, 16'h0006);

    // R7 falling edge in bidirectional mode does nothing; R10 hold
    extPin = 1; idle("R7", 3);
    extPin = 0; idle("R10", 5);
    readReg(2'd1, v); check("R7 R10 count held", v, 16'hFFFF);

    // R9 write collides with wrap
    wr("R9", 2'd0, 16'h0000);
    wr("R9", 2'd1, 16'hFFFF);
    doCycle("R9", 1, 1, 2'd1, 16'h5555);
    readReg(2'd1, v); check("R9 write wins", v, 16'h5555);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic t, w;
      logic [1:0] a;
      logic [W-1:0] d;
      t = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 15) == 0) extPin = ~extPin;
      w = ($urandom_range(0, 19) == 0);
      a = 2'($urandom_range(0, 3));
      d = 16'($urandom);
      if (a == 2'd1 && d[0]) d = 16'hFFF0 | (d & 16'h000F);
      if (a == 2'd2 && d[1]) d = d & 16'h000F;
      if (a == 2'd1 && d[2] && !d[0]) d = mReload + 16'(d[4:3]);
      if (a == 2'd0) d = d & 16'h000F;
      doCycle("R3 R5 R6 R8 random", t, w, a, d);
      if (i % 50 == 0) checkCtrl("R2 random ctrl");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule